// File: doc/BRIEF.md
# Pointer-Masking Control Register Unit

This block holds the configuration state for a pointer-masking feature on a core with machine, supervisor and user privilege levels. It contains one machine-level control register and six full-width registers: a mask and a base for each of the three levels. The supervisor and user control addresses do not have storage of their own. They are filtered windows onto the machine control register. A read returns only the fields that level may see. A write replaces only those fields and leaves the rest unchanged.

Requests arrive on a single-cycle CSR port. Read data, the illegal-access flag, the status-dirty pulse and the reserved-bit violation flag are all combinational in the request cycle. Register updates take effect at the next clock edge. The block decides whether an access is permitted. It drops writes that a level makes to its own registers while that level's "current" bit is clear. It forces the hardwired control bits and marks the extension state dirty. It also signals the processor status register so that the status register can record the dirty state.

Addresses use a 12-bit CSR number. The owning level sits in bits [9:8]: 0 is user, 1 is supervisor, 3 is machine. Bits [7:0] select the register: 0xC0 is control, 0xC1 is mask, 0xC2 is base. Bits [11:10] are zero. The resulting addresses are 0x0C0–0x0C2, 0x1C0–0x1C2 and 0x3C0–0x3C2.

Top module: `pm_csr_unit`

## Requirements
- R1: When `feat_en` is 0, every request to one of the nine decoded addresses raises `illegal`, returns `rd_data` 0, does not pulse `xs_dirty_set` and changes no register.
- R2: The owning level of an address is bits [9:8], and only the nine listed addresses are decoded. Any other address gives `illegal`=0, `rd_data`=0 and no state change. An access from a privilege (`req_priv`: U=0, S=1, M=3) numerically below the owner raises `illegal`.
- R3: A permitted write from a privilege above the owning level always takes effect, whatever the owner's current bit is.
- R4: A write from the owning level itself is dropped silently when that level's current bit is 0. The current bits are control bit 3 (M), bit 8 (S) and bit 13 (U). A dropped write gives no `illegal`, no `xs_dirty_set` and no register change.
- R5: Control bit 3 (machine current enable) is 1 after reset and after every control write.
- R6: The instruction-masking bits 4, 9 and 14 are 0 after every control write.
- R7: The field layout is: bits [1:0] extension state; bits [4:2] M, [9:7] S and [14:12] U, each group ordered enable, current, instruction from low to high. The view masks are 0x739F for M, 0x7383 for S and 0x7003 for U. A control read returns the machine register ANDed with the addressed view. A control write keeps the machine register bits outside that view.
- R8: Every accepted write to any of the nine registers pulses `xs_dirty_set` in the request cycle. From the next cycle, it also sets control bits [1:0] to Dirty (3). The state encodings are Off=0, Initial=1, Clean=2, Dirty=3.
- R9: Reset loads the control register with 0x0009 (state Initial, M current set) and all mask and base registers with 0.
- R10: Control write data bits outside the addressed view are discarded, and reserved control bits always read 0. `wpri_viol` is high in the cycle of any non-illegal control write that carries such bits, including a dropped write.
- R11: Mask and base registers store and return all XLEN bits of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Pointer-masking feature enabled |
| req_valid | input | 1 | CSR request present this cycle |
| req_addr | input | 12 | CSR number |
| req_we | input | 1 | Request is a write |
| req_wdata | input | XLEN | Write data |
| req_priv | input | 2 | Privilege of the requester (U=0, S=1, M=3) |
| rd_data | output | XLEN | Read data of the addressed register before any write |
| illegal | output | 1 | Access must raise an illegal-instruction exception |
| xs_dirty_set | output | 1 | Request to set the status register's extension state to Dirty |
| wpri_viol | output | 1 | Control write carried bits outside its view |

## Verification
The hardest case to reach is a silently dropped same-level write. It needs a lower level's current bit to be cleared by an earlier machine write, and then a write from exactly that level. The readback afterwards must show that nothing changed, not even the dirty state. The bench reaches it with a sweep over feature enable, requester level, owner level, register kind and several data patterns. The machine-level control writes inside the sweep keep toggling the supervisor and user current bits, so later writes from those levels are alternately accepted and dropped. After every access, the whole control register and the target register are read back from machine level and compared with an arithmetic model.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;

  localparam int CSR_AW     = 12;
  localparam int CTL_W      = 15;
  localparam int N_LVL      = 3;
  localparam int GRP0_LSB   = 2;
  localparam int GRP_STRIDE = 5;
  localparam int EN_OFF     = 0;
  localparam int CUR_OFF    = 1;
  localparam int INS_OFF    = 2;
  localparam logic [7:0] PM_PAGE = 8'hC0;

  typedef enum logic [1:0] {PLV_U = 2'd0, PLV_S = 2'd1, PLV_H = 2'd2, PLV_M = 2'd3} plv_e;
  typedef enum logic [1:0] {KIND_CTL = 2'd0, KIND_MASK = 2'd1, KIND_BASE = 2'd2, KIND_NONE = 2'd3} kind_e;
  typedef enum logic [1:0] {XST_OFF = 2'd0, XST_INIT = 2'd1, XST_CLEAN = 2'd2, XST_DIRTY = 2'd3} xst_e;

  // group index: machine 0, supervisor 1, user 2
  function automatic logic [1:0] grp_of(logic [1:0] lvl);
    case (lvl)
      PLV_M:   return 2'd0;
      PLV_S:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [CTL_W-1:0] grp_field(int idx);
    logic [CTL_W-1:0] r;
    r = '0;
    r[GRP0_LSB + GRP_STRIDE*idx +: 3] = 3'b111;
    return r;
  endfunction

  // a level sees the state field plus its own group and all lower groups
  function automatic logic [CTL_W-1:0] view_mask(logic [1:0] lvl);
    logic [CTL_W-1:0] r;
    r = CTL_W'(3);
    for (int g = 0; g < N_LVL; g++)
      if (g >= int'(grp_of(lvl))) r |= grp_field(g);
    return r;
  endfunction

  function automatic int cur_pos(logic [1:0] lvl);
    return GRP0_LSB + GRP_STRIDE*int'(grp_of(lvl)) + CUR_OFF;
  endfunction

  // hardwired bits and dirty marking applied to every control write
  function automatic logic [CTL_W-1:0] ctl_legalize(logic [CTL_W-1:0] v);
    logic [CTL_W-1:0] r;
    r = v;
    for (int g = 0; g < N_LVL; g++)
      r[GRP0_LSB + GRP_STRIDE*g + INS_OFF] = 1'b0;
    r[GRP0_LSB + CUR_OFF] = 1'b1;
    r[1:0] = XST_DIRTY;
    return r;
  endfunction

  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) | (CTL_W'(1) << (GRP0_LSB + CUR_OFF));
  localparam logic [CTL_W-1:0] CTL_FULL  = view_mask(PLV_M);

endpackage

// File: rtl/pm_csr_decode.sv
module pm_csr_decode
  import pm_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CSR_AW-1:0]    req_addr,
  input  logic                 req_we,
  input  logic [1:0]           req_priv,
  input  logic                 feat_en,
  input  logic [CTL_W-1:0]     ctl_q,
  output logic                 hit,
  output logic                 acc_illegal,
  output logic                 wr_ok,
  output logic                 wr_dropped,
  output logic [1:0]           owner,
  output logic [1:0]           kind
);

  logic own_cur;
  logic addr_match;

  assign owner      = req_addr[9:8];
  assign kind       = req_addr[1:0];
  assign addr_match = (req_addr[11:10] == 2'b00) &&
                      (req_addr[7:2] == PM_PAGE[7:2]) &&
                      (req_addr[1:0] != KIND_NONE) &&
                      (owner != PLV_H);
  assign hit        = req_valid && addr_match;
  assign own_cur    = ctl_q[cur_pos(owner)];

  assign acc_illegal = hit && (!feat_en || (req_priv < owner));
  assign wr_dropped  = hit && req_we && !acc_illegal && (req_priv == owner) && !own_cur;
  assign wr_ok       = hit && req_we && !acc_illegal && !wr_dropped;

  // R2: a requester below the owner never gets a write through
  p_low_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (req_priv < owner)) |-> (acc_illegal && !wr_ok));

  // R4: a dropped write is never also reported illegal
  p_drop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |-> (!acc_illegal && !wr_ok));

endmodule

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import pm_csr_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_attempt,
  input  logic             ctl_we,
  input  logic             any_we,
  input  logic [1:0]       owner,
  input  logic [XLEN-1:0]  wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CTL_W-1:0] ctl_view,
  output logic             wpri_bad
);

  logic [CTL_W-1:0] vmask;
  logic [XLEN-1:0]  vmask_ext;
  logic [CTL_W-1:0] merged;
  logic [CTL_W-1:0] ctl_d;

  assign vmask     = view_mask(owner);
  assign vmask_ext = {{(XLEN-CTL_W){1'b0}}, vmask};
  assign merged    = (wdata[CTL_W-1:0] & vmask) | (ctl_q & ~vmask);
  assign ctl_view  = ctl_q & vmask;
  assign wpri_bad  = ctl_attempt && ((wdata & ~vmask_ext) != '0);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we)       ctl_d = ctl_legalize(merged);
    else if (any_we)  ctl_d = {ctl_q[CTL_W-1:2], XST_DIRTY};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  p_mcur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_q[GRP0_LSB + CUR_OFF]);

  p_insn_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (!ctl_q[4] && !ctl_q[9] && !ctl_q[14]));

  p_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |=> (ctl_q[1:0] == XST_DIRTY));

  // R7: a user-view write leaves machine and supervisor enable/current bits alone
  p_merge_u_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && owner == PLV_U) |=> (ctl_q[8:7] == $past(ctl_q[8:7]) && ctl_q[2] == $past(ctl_q[2])));

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~CTL_FULL) == '0);

endmodule

// File: rtl/pm_mb_bank.sv
module pm_mb_bank
  import pm_csr_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      grp,
  input  logic            sel_base,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rd
);

  localparam int N_REG = N_LVL * 2;

  logic [XLEN-1:0] rd_vec [N_REG];

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    for (genvar k = 0; k < 2; k++) begin : g_reg
      logic [XLEN-1:0] q_r;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q_r <= '0;
        else if (we && (grp == 2'(g)) && (sel_base == k[0]))
          q_r <= wdata;
      end
      assign rd_vec[g*2 + k] = q_r;
    end
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < N_REG; i++)
      if (i == int'(grp)*2 + int'(sel_base)) rd = rd_vec[i];
  end

endmodule

// File: rtl/pm_csr_unit.sv
module pm_csr_unit
  import pm_csr_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              req_valid,
  input  logic [11:0]       req_addr,
  input  logic              req_we,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [1:0]        req_priv,
  output logic [XLEN-1:0]   rd_data,
  output logic              illegal,
  output logic              xs_dirty_set,
  output logic              wpri_viol
);

  logic             hit, acc_illegal, wr_ok, wr_dropped;
  logic [1:0]       owner, kind;
  logic [CTL_W-1:0] ctl_q, ctl_view;
  logic             is_ctl, ctl_attempt, wpri_bad;
  logic [XLEN-1:0]  mb_rd;

  pm_csr_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
    .req_priv(req_priv), .feat_en(feat_en), .ctl_q(ctl_q),
    .hit(hit), .acc_illegal(acc_illegal), .wr_ok(wr_ok),
    .wr_dropped(wr_dropped), .owner(owner), .kind(kind)
  );

  assign is_ctl      = (kind == KIND_CTL);
  assign ctl_attempt = hit && req_we && !acc_illegal && is_ctl;

  pm_ctl_reg #(.XLEN(XLEN)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_attempt(ctl_attempt), .ctl_we(wr_ok && is_ctl), .any_we(wr_ok),
    .owner(owner), .wdata(req_wdata),
    .ctl_q(ctl_q), .ctl_view(ctl_view), .wpri_bad(wpri_bad)
  );

  pm_mb_bank #(.XLEN(XLEN)) u_mb (
    .clk(clk), .rst_n(rst_n),
    .we(wr_ok && !is_ctl), .grp(grp_of(owner)), .sel_base(kind == KIND_BASE),
    .wdata(req_wdata), .rd(mb_rd)
  );

  always_comb begin
    if (!hit || acc_illegal) rd_data = '0;
    else if (is_ctl)         rd_data = {{(XLEN-CTL_W){1'b0}}, ctl_view};
    else                     rd_data = mb_rd;
  end

  assign illegal      = acc_illegal;
  assign xs_dirty_set = wr_ok;
  assign wpri_viol    = wpri_bad;

  p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !feat_en) |-> (illegal && rd_data == '0 && !xs_dirty_set));

  p_illegal_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(ctl_q));

  p_drop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> $stable(ctl_q));

  p_xs_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xs_dirty_set |-> (!illegal && req_we));

endmodule

// File: tb/tb_pm_csr_unit.sv
`timescale 1ns/1ps
module tb_pm_csr_unit;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            feat_en;
  logic            req_valid;
  logic [11:0]     req_addr;
  logic            req_we;
  logic [XLEN-1:0] req_wdata;
  logic [1:0]      req_priv;
  logic [XLEN-1:0] rd_data;
  logic            illegal, xs_dirty_set, wpri_viol;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_ctl;
  logic [31:0] m_mask [3];
  logic [31:0] m_base [3];

  always #2.5 clk = ~clk;

  pm_csr_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_priv(req_priv),
    .rd_data(rd_data), .illegal(illegal), .xs_dirty_set(xs_dirty_set), .wpri_viol(wpri_viol)
  );

  function automatic int bgrp(logic [1:0] own);
    return (own == 2'd3) ? 0 : (own == 2'd1) ? 1 : 2;
  endfunction

  function automatic logic [31:0] bview(logic [1:0] own);
    logic [31:0] r;
    r = 32'h3;
    for (int g = bgrp(own); g < 3; g++) r = r | (32'h7 << (2 + 5*g));
    return r;
  endfunction

  function automatic bit bhit(logic [11:0] a);
    return (a[11:10] == 2'b00) && (a[9:8] != 2'd2) &&
           (a[7:0] == 8'hC0 || a[7:0] == 8'hC1 || a[7:0] == 8'hC2);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic fe, input logic [1:0] pv, input logic [11:0] ad,
                        input logic w, input logic [31:0] wd, input string rtag);
    bit h, e_ill, drop, acc, e_wpri;
    logic [1:0] own;
    int g;
    logic [31:0] vm, e_rd, nv;
    h    = bhit(ad);
    own  = ad[9:8];
    g    = bgrp(own);
    vm   = bview(own);
    e_ill = h && (!fe || pv < own);
    drop = h && w && !e_ill && (pv == own) && !m_ctl[3 + 5*g];
    acc  = h && w && !e_ill && !drop;
    e_wpri = h && w && !e_ill && (ad[1:0] == 2'd0) && ((wd & ~vm) != 0);
    if (!h || e_ill)          e_rd = 0;
    else if (ad[1:0] == 2'd0) e_rd = m_ctl & vm;
    else if (ad[1:0] == 2'd1) e_rd = m_mask[g];
    else                      e_rd = m_base[g];

    @(negedge clk);
    feat_en = fe; req_priv = pv; req_addr = ad; req_we = w; req_wdata = wd; req_valid = 1'b1;
    #1;
    chk(!fe ? "R1" : "R2", {31'b0, illegal}, {31'b0, e_ill});
    chk(rtag, rd_data, e_rd);
    chk(drop ? "R4" : "R8", {31'b0, xs_dirty_set}, {31'b0, acc});
    chk("R10", {31'b0, wpri_viol}, {31'b0, e_wpri});
    @(posedge clk);
    #0.5;
    if (acc) begin
      if (ad[1:0] == 2'd0) begin
        nv = (wd & vm) | (m_ctl & ~vm);
        nv = nv | 32'h8;
        nv = nv & ~(32'h10 | 32'h200 | 32'h4000);
        m_ctl = nv;
      end else if (ad[1:0] == 2'd1) m_mask[g] = wd;
      else m_base[g] = wd;
      m_ctl[1:0] = 2'd3;
    end
  endtask

  function automatic logic [31:0] pat(int i);
    case (i)
      0: return 32'hFFFF_FFFF;
      1: return 32'h0000_2100;
      2: return 32'hA5A5_5A5A;
      default: return 32'h0000_0000;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; feat_en = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_we = 1'b0; req_wdata = '0; req_priv = 2'd0;
    m_ctl = 32'h9;
    for (int i = 0; i < 3; i++) begin m_mask[i] = 0; m_base[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    access(1, 2'd3, 12'h3C0, 0, 0, "R9");
    access(1, 2'd3, 12'h0C1, 0, 0, "R9");
    access(1, 2'd3, 12'h1C2, 0, 0, "R9");
    // own-level write with S current clear is dropped
    access(1, 2'd1, 12'h1C0, 1, 32'h0000_0180, "R7");
    access(1, 2'd3, 12'h3C0, 0, 0, "R4");
    // machine writes S mask regardless of S current bit
    access(1, 2'd3, 12'h1C1, 1, 32'hDEAD_BEEF, "R11");
    access(1, 2'd3, 12'h1C1, 0, 0, "R3");
    access(1, 2'd1, 12'h1C1, 0, 0, "R11");
    // all-ones control write: hardwired bits and reserved bits
    access(1, 2'd3, 12'h3C0, 1, 32'hFFFF_FFFF, "R7");
    access(1, 2'd3, 12'h3C0, 0, 0, "R6");
    access(1, 2'd1, 12'h1C0, 0, 0, "R7");
    access(1, 2'd0, 12'h0C0, 0, 0, "R7");
    access(1, 2'd3, 12'h3C0, 1, 32'h0, "R7");
    access(1, 2'd3, 12'h3C0, 0, 0, "R5");
    // feature off
    access(0, 2'd3, 12'h3C2, 1, 32'h1234_5678, "R1");
    access(1, 2'd3, 12'h3C2, 0, 0, "R1");

    // sweep
    for (int fe = 0; fe < 2; fe++)
      for (int pi = 0; pi < 3; pi++)
        for (int ow = 0; ow < 4; ow++)
          for (int k = 0; k < 4; k++)
            for (int p = 0; p < 4; p++) begin
              logic [1:0] pv;
              logic [11:0] ad;
              pv = (pi == 2) ? 2'd3 : 2'(pi);
              ad = {2'b00, 2'(ow), 6'b110000, 2'(k)};
              access(fe[0], pv, ad, 1'b1, pat(p) ^ (32'(k) << 20), bhit(ad) ? "R7" : "R2");
              access(1, 2'd3, 12'h3C0, 0, 0, "R5");
              if (bhit(ad) && k != 0) access(1, 2'd3, ad, 0, 0, "R11");
              else if (bhit(ad))      access(1, 2'd3, ad, 0, 0, "R7");
              // set S and U current per pattern so later writes alternate between accepted and dropped
              if (p == 3) access(1, 2'd3, 12'h3C0, 1, (ow[0] ? 32'h2100 : 32'h0), "R7");
            end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule